// File: doc/BRIEF.md
# Multi-line terminal scanner and interrupt arbiter

This block watches a bank of serial line ports and picks out the next line that needs the host's attention. Each port is modelled by two request levels: one says a received character is waiting and the other says the transmitter can take a new character. A scan pointer visits one line per clock. It stops on the first line that needs service, records the line and which kind of event it found, and raises a host interrupt on a programmable 3-bit priority channel. When a received character stops the scan, it is latched and the port gets a one-cycle take pulse.

The host talks to the block through a single-cycle command port with four operations: put a character, get a character, write control, and read status. The scanner stays parked on its line until the host acts. A get clears the receive flag. A put that falls back to the scanned line clears the transmit flag. A restart control clears everything. Transmitter-ready events matter only for lines the host has switched on by writing a character to them.

Top module: `tty_scan_arbiter`

## Requirements
- R1: While neither flag is set and no command is presented, the scanner examines line `ptr` on each clock and then moves `ptr` to the next line, wrapping from the last line to 0. On a stop it records `ptr` in `stop_line` and stays stopped while either flag is set. In any cycle that carries a command, no line is examined.
- R2: A line with a receive request stops the scan with `rx_flag` set, even when its transmitter is also ready. `rx_flag` and `tx_flag` are never both high.
- R3: A transmitter-ready request on a line whose active bit is clear does not stop the scan. The next line is examined on the following clock.
- R4: The put command (op 0) takes use-line in bit 15, turn-off in bit 14, the line in bits 11:8 and the character in bits 7:0. With use-line set, the target is `stop_line` if `tx_flag` is set and the given line otherwise. With use-line clear, the target is `stop_line` if either flag is set, and otherwise the command has no effect.
- R5: A put without turn-off sets the target's `tx_active` bit. On the next cycle it pulses `tx_strobe` for one cycle, with `tx_line` equal to the target and `tx_char` equal to the character. A put with turn-off clears the target's active bit and sends nothing.
- R6: A put whose target came from `stop_line` clears `tx_flag`, so scanning resumes.
- R7: Get (op 1) returns, in the same cycle, `rd_data` with bit 15 = 0 (modem flag), bits 12:9 = `stop_line`, bit 8 = `rx_flag`, bits 7:0 = the latched character. It clears `rx_flag` at that clock edge.
- R8: Status read (op 3) returns `rd_data` with bit 4 = `rx_flag`, bit 3 = `tx_flag`, bits 2:0 = channel and all other bits 0, and changes no state. With no get or status command, `rd_data` is 0.
- R9: `irq` is high exactly when a flag is set and the channel is non-zero. With channel 0 the flags are still recorded.
- R10: Control (op 2) loads the channel from bits 2:0, or loads 0 if the clear bit (bit 4) is set. If bit 3 (restart) or bit 4 is set, it also clears every active bit, both flags, `stop_line` and the scan pointer.
- R11: A receive stop latches that line's character into `rx_char`. On the same cycle that `rx_flag` rises, `rx_pop` pulses for one cycle with only that line's bit set.
- R12: After reset, all outputs are 0 and the scan starts at line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_req | input | NUM_LINES | Per-line received-character-waiting level |
| rx_data | input | NUM_LINES*CHAR_W | Per-line received character, line i at bits i*CHAR_W |
| tx_ready | input | NUM_LINES | Per-line transmitter-ready level |
| cmd_valid | input | 1 | Host command strobe, one cycle per command |
| cmd_op | input | 2 | 0 put, 1 get, 2 control, 3 status |
| cmd_wdata | input | 16 | Command word |
| rd_data | output | 16 | Read word for get and status, same cycle |
| irq | output | 1 | Host interrupt request |
| irq_chan | output | CHAN_W | Programmed priority channel |
| stop_line | output | log2(NUM_LINES) | Line the scanner stopped on |
| rx_flag | output | 1 | Stopped on a receive event |
| tx_flag | output | 1 | Stopped on a transmit-ready event |
| rx_char | output | CHAR_W | Latched received character |
| rx_pop | output | NUM_LINES | One-cycle take pulse to the port whose character was latched |
| tx_active | output | NUM_LINES | Per-line transmitter-active flags |
| tx_strobe | output | 1 | One-cycle send pulse |
| tx_line | output | log2(NUM_LINES) | Line of the character being sent |
| tx_char | output | CHAR_W | Character being sent |

## Verification
A wrong scan pointer shows up as a stop on the wrong line, or on the right line a cycle early or late. The reference model compares `stop_line` and both flags on every clock, so such a fault is caught in the cycle the stop happens. A corrupted active bit appears at once on `tx_active`. Within one scan lap, at most 16 cycles, it also shows as a missing or spurious transmit stop. Misrouting of a put appears on the next cycle in `tx_line`, `tx_strobe` and `tx_flag`.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_CTRL = 2'd2,
        OP_STAT = 2'd3
    } cmd_op_e;

    localparam int WORD_W       = 16;
    // put command fields
    localparam int PUT_USE      = 15;
    localparam int PUT_OFF      = 14;
    localparam int PUT_LINE_LSB = 8;
    // control command fields
    localparam int CTRL_CLEAR   = 4;
    localparam int CTRL_RESTART = 3;
    // read word fields
    localparam int RD_MODEM     = 15;
    localparam int RD_LINE_LSB  = 9;
    localparam int RD_RX        = 8;
    localparam int ST_RX        = 4;
    localparam int ST_TX        = 3;

endpackage

// File: rtl/tsa_line_probe.sv
module tsa_line_probe #(
    parameter int NUM_LINES = 16,
    parameter int CHAR_W    = 8,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic [LINE_W-1:0]           ptr,
    input  logic [NUM_LINES-1:0]        rx_req,
    input  logic [NUM_LINES*CHAR_W-1:0] rx_data,
    input  logic [NUM_LINES-1:0]        tx_ready,
    input  logic [NUM_LINES-1:0]        active,
    output logic                        hit_rx,
    output logic                        hit_tx,
    output logic [CHAR_W-1:0]           lane_char
);
    logic [CHAR_W-1:0] lanes [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
        assign lanes[g] = rx_data[g*CHAR_W +: CHAR_W];
    end

    // receive is looked at first; transmit only counts on an active line
    assign hit_rx    = rx_req[ptr];
    assign hit_tx    = tx_ready[ptr] & active[ptr];
    assign lane_char = lanes[ptr];
endmodule

// File: rtl/tsa_put_route.sv
module tsa_put_route #(
    parameter int NUM_LINES = 16,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic              use_line,
    input  logic [LINE_W-1:0] given_line,
    input  logic              rxf,
    input  logic              txf,
    input  logic [LINE_W-1:0] scan_line,
    output logic              take,
    output logic              from_scan,
    output logic [LINE_W-1:0] target
);
    always_comb begin
        take      = 1'b0;
        from_scan = 1'b0;
        target    = given_line;
        if (use_line && txf) begin
            take      = 1'b1;
            from_scan = 1'b1;
            target    = scan_line;
        end else if (use_line) begin
            take      = 1'b1;
        end else if (rxf || txf) begin
            take      = 1'b1;
            from_scan = 1'b1;
            target    = scan_line;
        end
    end
endmodule

// File: rtl/tsa_word_fmt.sv
module tsa_word_fmt
    import tsa_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int CHAR_W    = 8,
    parameter int CHAN_W    = 3,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic              valid,
    input  logic [1:0]        op,
    input  logic [LINE_W-1:0] line,
    input  logic              rxf,
    input  logic              txf,
    input  logic [CHAR_W-1:0] chr,
    input  logic [CHAN_W-1:0] chan,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = '0;
        if (valid && cmd_op_e'(op) == OP_GET) begin
            word[RD_MODEM]                  = 1'b0;
            word[RD_LINE_LSB +: LINE_W]     = line;
            word[RD_RX]                     = rxf;
            word[CHAR_W-1:0]                = chr;
        end else if (valid && cmd_op_e'(op) == OP_STAT) begin
            word[ST_RX]                     = rxf;
            word[ST_TX]                     = txf;
            word[CHAN_W-1:0]                = chan;
        end
    end
endmodule

// File: rtl/tty_scan_arbiter.sv
module tty_scan_arbiter
    import tsa_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int CHAR_W    = 8,
    parameter int CHAN_W    = 3,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        rx_req,
    input  logic [NUM_LINES*CHAR_W-1:0] rx_data,
    input  logic [NUM_LINES-1:0]        tx_ready,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [15:0]                 cmd_wdata,
    output logic [15:0]                 rd_data,
    output logic                        irq,
    output logic [CHAN_W-1:0]           irq_chan,
    output logic [LINE_W-1:0]           stop_line,
    output logic                        rx_flag,
    output logic                        tx_flag,
    output logic [CHAR_W-1:0]           rx_char,
    output logic [NUM_LINES-1:0]        rx_pop,
    output logic [NUM_LINES-1:0]        tx_active,
    output logic                        tx_strobe,
    output logic [LINE_W-1:0]           tx_line,
    output logic [CHAR_W-1:0]           tx_char
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

    typedef struct packed {
        logic [LINE_W-1:0]    ptr;
        logic [LINE_W-1:0]    line;
        logic                 rxf;
        logic                 txf;
        logic [CHAR_W-1:0]    chr;
        logic [CHAN_W-1:0]    chan;
        logic [NUM_LINES-1:0] act;
        logic [NUM_LINES-1:0] pop;
        logic                 strobe;
        logic [LINE_W-1:0]    tline;
        logic [CHAR_W-1:0]    tchar;
    } scan_state_t;

    scan_state_t st_d, st_q;

    logic              probe_rx, probe_tx;
    logic [CHAR_W-1:0] probe_char;
    logic              route_take, route_scan;
    logic [LINE_W-1:0] route_tgt;
    logic [1:0]        unused_wbits;

    assign unused_wbits = cmd_wdata[13:12];

    tsa_line_probe #(.NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W)) u_probe (
        .ptr       (st_q.ptr),
        .rx_req    (rx_req),
        .rx_data   (rx_data),
        .tx_ready  (tx_ready),
        .active    (st_q.act),
        .hit_rx    (probe_rx),
        .hit_tx    (probe_tx),
        .lane_char (probe_char)
    );

    tsa_put_route #(.NUM_LINES(NUM_LINES)) u_route (
        .use_line   (cmd_wdata[PUT_USE]),
        .given_line (cmd_wdata[PUT_LINE_LSB +: LINE_W]),
        .rxf        (st_q.rxf),
        .txf        (st_q.txf),
        .scan_line  (st_q.line),
        .take       (route_take),
        .from_scan  (route_scan),
        .target     (route_tgt)
    );

    tsa_word_fmt #(.NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W), .CHAN_W(CHAN_W)) u_fmt (
        .valid (cmd_valid),
        .op    (cmd_op),
        .line  (st_q.line),
        .rxf   (st_q.rxf),
        .txf   (st_q.txf),
        .chr   (st_q.chr),
        .chan  (st_q.chan),
        .word  (rd_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.pop    = '0;
        st_d.strobe = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op_e'(cmd_op))
                OP_PUT: begin
                    if (route_take) begin
                        if (cmd_wdata[PUT_OFF]) begin
                            st_d.act[route_tgt] = 1'b0;
                        end else begin
                            st_d.act[route_tgt] = 1'b1;
                            st_d.strobe         = 1'b1;
                            st_d.tline          = route_tgt;
                            st_d.tchar          = cmd_wdata[CHAR_W-1:0];
                        end
                        if (route_scan) st_d.txf = 1'b0;
                    end
                end
                OP_GET: st_d.rxf = 1'b0;
                OP_CTRL: begin
                    if (cmd_wdata[CTRL_RESTART] || cmd_wdata[CTRL_CLEAR]) begin
                        st_d.act  = '0;
                        st_d.rxf  = 1'b0;
                        st_d.txf  = 1'b0;
                        st_d.line = '0;
                        st_d.ptr  = '0;
                    end
                    st_d.chan = cmd_wdata[CTRL_CLEAR] ? '0 : cmd_wdata[CHAN_W-1:0];
                end
                OP_STAT: ;
            endcase
        end else if (!(st_q.rxf || st_q.txf)) begin
            if (probe_rx) begin
                st_d.rxf          = 1'b1;
                st_d.line         = st_q.ptr;
                st_d.chr          = probe_char;
                st_d.pop[st_q.ptr] = 1'b1;
            end else if (probe_tx) begin
                st_d.txf  = 1'b1;
                st_d.line = st_q.ptr;
            end
            st_d.ptr = (st_q.ptr == LAST_LINE) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq       = (st_q.rxf || st_q.txf) && (st_q.chan != '0);
    assign irq_chan  = st_q.chan;
    assign stop_line = st_q.line;
    assign rx_flag   = st_q.rxf;
    assign tx_flag   = st_q.txf;
    assign rx_char   = st_q.chr;
    assign rx_pop    = st_q.pop;
    assign tx_active = st_q.act;
    assign tx_strobe = st_q.strobe;
    assign tx_line   = st_q.tline;
    assign tx_char   = st_q.tchar;
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker #(
    parameter int NUM_LINES = 16,
    parameter int CHAN_W    = 3,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [1:0]           cmd_op,
    input logic                 ctl_restart,
    input logic                 irq,
    input logic [CHAN_W-1:0]    irq_chan,
    input logic [LINE_W-1:0]    stop_line,
    input logic                 rx_flag,
    input logic                 tx_flag,
    input logic [NUM_LINES-1:0] rx_pop,
    input logic [NUM_LINES-1:0] tx_active,
    input logic                 tx_strobe,
    input logic [LINE_W-1:0]    tx_line
);
    p_exclusive_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_flag && tx_flag));

    p_irq_needs_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_chan != '0) && (rx_flag || tx_flag));

    p_stop_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag || tx_flag) && !cmd_valid |=> $stable(stop_line));

    p_pop_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop != '0) |-> rx_flag && ($countones(rx_pop) == 1));

    p_get_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd1 |=> !rx_flag);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd2 && ctl_restart |=>
            tx_active == '0 && !rx_flag && !tx_flag && stop_line == '0);

    p_strobe_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> tx_active[tx_line]);
endmodule

bind tty_scan_arbiter tsa_checker #(.NUM_LINES(NUM_LINES), .CHAN_W(CHAN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .ctl_restart (cmd_wdata[3]),
    .irq         (irq),
    .irq_chan    (irq_chan),
    .stop_line   (stop_line),
    .rx_flag     (rx_flag),
    .tx_flag     (tx_flag),
    .rx_pop      (rx_pop),
    .tx_active   (tx_active),
    .tx_strobe   (tx_strobe),
    .tx_line     (tx_line)
);

// File: tb/tty_scan_arbiter_test.sv
module tty_scan_arbiter_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  rx_req = '0;
    logic [127:0] rx_data = '0;
    logic [15:0]  tx_ready = '0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = '0;
    logic [15:0]  cmd_wdata = '0;
    logic [15:0]  rd_data;
    logic         irq;
    logic [2:0]   irq_chan;
    logic [3:0]   stop_line;
    logic         rx_flag, tx_flag;
    logic [7:0]   rx_char;
    logic [15:0]  rx_pop;
    logic [15:0]  tx_active;
    logic         tx_strobe;
    logic [3:0]   tx_line;
    logic [7:0]   tx_char;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    int       m_ptr, m_line;
    bit       m_rx, m_tx, m_strobe;
    bit [7:0] m_chr, m_tc;
    bit [2:0] m_chan;
    bit [3:0] m_tl;
    bit [15:0] m_act, m_pop;

    always #4 clk = ~clk;

    tty_scan_arbiter uut (
        .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .rx_data(rx_data),
        .tx_ready(tx_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .rd_data(rd_data), .irq(irq), .irq_chan(irq_chan),
        .stop_line(stop_line), .rx_flag(rx_flag), .tx_flag(tx_flag),
        .rx_char(rx_char), .rx_pop(rx_pop), .tx_active(tx_active),
        .tx_strobe(tx_strobe), .tx_line(tx_line), .tx_char(tx_char)
    );

    task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        logic [15:0] w = '0;
        if (cmd_valid && cmd_op == 2'd1) begin
            w[12:9] = 4'(m_line); w[8] = m_rx; w[7:0] = m_chr;   // R7
        end else if (cmd_valid && cmd_op == 2'd3) begin
            w[4] = m_rx; w[3] = m_tx; w[2:0] = m_chan;           // R8
        end
        return w;
    endfunction

    task automatic model_reset();
        m_ptr = 0; m_line = 0; m_rx = 0; m_tx = 0; m_strobe = 0;
        m_chr = 0; m_tc = 0; m_chan = 0; m_tl = 0; m_act = 0; m_pop = 0;
    endtask

    task automatic model_step();
        int t;
        bit take, fb;
        m_pop = 0; m_strobe = 0;
        if (cmd_valid) begin
            case (cmd_op)
                2'd0: begin
                    take = 1; fb = 0; t = int'(cmd_wdata[11:8]);
                    if (cmd_wdata[15] && m_tx) begin t = m_line; fb = 1; end
                    else if (cmd_wdata[15]) fb = 0;
                    else if (m_rx || m_tx) begin t = m_line; fb = 1; end
                    else take = 0;
                    if (take) begin
                        if (cmd_wdata[14]) m_act[t] = 0;
                        else begin m_act[t] = 1; m_strobe = 1; m_tl = 4'(t); m_tc = cmd_wdata[7:0]; end
                        if (fb) m_tx = 0;
                    end
                end
                2'd1: m_rx = 0;
                2'd2: begin
                    if (cmd_wdata[3] || cmd_wdata[4]) begin
                        m_act = 0; m_rx = 0; m_tx = 0; m_line = 0; m_ptr = 0;
                    end
                    m_chan = cmd_wdata[4] ? 3'd0 : cmd_wdata[2:0];
                end
                default: ;
            endcase
        end else if (!(m_rx || m_tx)) begin
            if (rx_req[m_ptr]) begin
                m_rx = 1; m_line = m_ptr; m_chr = rx_data[m_ptr*8 +: 8]; m_pop[m_ptr] = 1;
            end else if (tx_ready[m_ptr] && m_act[m_ptr]) begin
                m_tx = 1; m_line = m_ptr;
            end
            m_ptr = (m_ptr + 1) % 16;
        end
    endtask

    // one clock: compare, advance, then retire port requests and the command
    task automatic cyc();
        #1;
        chk("R7", "rd_data", 32'(rd_data), 32'(exp_rd()));
        chk("R9", "irq", 32'(irq), 32'((m_rx || m_tx) && m_chan != 0));
        chk("R10", "irq_chan", 32'(irq_chan), 32'(m_chan));
        chk("R1", "stop_line", 32'(stop_line), 32'(m_line));
        chk("R2", "rx_flag", 32'(rx_flag), 32'(m_rx));
        chk("R1", "tx_flag", 32'(tx_flag), 32'(m_tx));
        chk("R11", "rx_char", 32'(rx_char), 32'(m_chr));
        chk("R11", "rx_pop", 32'(rx_pop), 32'(m_pop));
        chk("R5", "tx_active", 32'(tx_active), 32'(m_act));
        chk("R5", "tx_strobe", 32'(tx_strobe), 32'(m_strobe));
        chk("R4", "tx_line", 32'(tx_line), 32'(m_tl));
        chk("R5", "tx_char", 32'(tx_char), 32'(m_tc));
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        @(negedge clk);
        for (int i = 0; i < 16; i++) if (m_pop[i]) rx_req[i] = 1'b0;
        cmd_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic issue(logic [1:0] op, logic [15:0] w);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = w; cyc();
    endtask

    task automatic put(bit use_l, bit off, int ln, logic [7:0] c);
        issue(2'd0, {use_l, off, 2'b00, 4'(ln), c});
    endtask

    task automatic ctrl(bit clr, bit restart, logic [2:0] ch);
        issue(2'd2, {11'd0, clr, restart, ch});
    endtask

    task automatic rx_line(int ln, logic [7:0] c);
        rx_data[ln*8 +: 8] = c; rx_req[ln] = 1'b1;
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        idle(3);                       // R12: reset values
        rst_n = 1'b1;
        issue(2'd3, 16'h0);            // R8: status after reset
        ctrl(0, 1, 3'd5);              // R10: channel 5
        rx_line(3, 8'hA5);
        idle(6);                       // R1, R11: stop on line 3, take pulse
        issue(2'd3, 16'h0);            // R8
        issue(2'd1, 16'h0);            // R7: get clears receive flag
        idle(2);
        put(1, 0, 6, 8'h41);           // R5: activate line 6
        idle(2);
        tx_ready[9] = 1'b1;            // R3: inactive line ready, ignored
        rx_line(6, 8'h5A);
        tx_ready[6] = 1'b1;
        idle(20);                      // R2: receive wins on line 6
        issue(2'd1, 16'h0);
        idle(20);                      // R1: wraps and stops on transmit of line 6
        put(1, 0, 2, 8'h43);           // R4: use-line redirected to scanned line
        idle(20);
        put(0, 1, 0, 8'h00);           // R6, R5: turn-off via scanned line
        idle(20);                      // R3: line 6 now inactive, no stop
        tx_ready[6] = 1'b0;
        put(0, 0, 5, 8'h44);           // R4: ignored while scanning
        idle(3);
        ctrl(0, 0, 3'd0);              // R9: channel 0
        rx_line(12, 8'h3C);
        idle(20);                      // R9: flag recorded, no irq
        issue(2'd3, 16'h0);
        issue(2'd1, 16'h0);
        ctrl(0, 0, 3'd4);
        rx_line(1, 8'h11);
        rx_line(2, 8'h22);
        idle(18);                      // R1: round robin over lines 1 and 2
        issue(2'd1, 16'h0);
        idle(3);
        issue(2'd1, 16'h0);
        put(1, 0, 1, 8'h55);
        put(1, 0, 14, 8'h66);
        ctrl(0, 1, 3'd2);              // R10: restart clears active flags
        idle(2);
        ctrl(1, 0, 3'd7);              // R10: clear bit forces channel 0
        idle(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule